// File: doc/BRIEF.md
# Opaque Memory Window Decoder

This block holds the configuration for one 64-bit memory window that a bus bridge must treat as private to the downstream side. Addresses inside the window are never claimed by the bridge, whether the transaction shows up on the upstream (primary) or the downstream (secondary) interface. The window is described by four registers: a lower and an upper half for the base, and the same two halves for the limit. A separate enable register switches it on. The window is sized in 1 MB units, so the low 20 address bits of the base are taken as zero and those of the limit as all ones.

Software reaches the registers through a simple word-select read/write port with per-byte write enables. Each side of the bridge presents its memory address on its own input and gets a combinational reject flag back. Bus protocol, forwarding and the other bridge windows are handled elsewhere.

Top module: `opq_window_decoder`

## Requirements
- R1: After reset the base-low and limit-low registers read 0xFFF1, base-high reads 0xFFFFFFFF, limit-high reads 0x00000000 and enable reads 0. No address is rejected, and this still holds if only the enable bit is then set.
- R2: In the base-low and limit-low registers, bits 3:0 always read 0001 and ignore writes. Bits 15:4 are writable and hold address bits 31:20. Bits 31:16 of the read data are 0.
- R3: A write changes only the bytes whose `cfg_be` bit is set. `cfg_be[n]` covers `cfg_wdata[8n+7:8n]`.
- R4: The register select codes are: 0 base-low, 1 limit-low, 2 base-high (address bits 63:32), 3 limit-high (address bits 63:32), 4 enable (bit 0). Codes 5 to 7 read 0, and writes to them change nothing.
- R5: The window base is {base-high, base-low[15:4], 20'h00000}. The window limit is {limit-high, limit-low[15:4], 20'hFFFFF}. An address is inside when base <= address <= limit, compared as unsigned 64-bit values.
- R6: When enable bit 0 is 0, neither reject output asserts.
- R7: When the base is greater than the limit, no address is rejected.
- R8: `pri_reject` depends only on `pri_addr` and `sec_reject` depends only on `sec_addr`. Equal addresses give equal results.
- R9: The reject outputs follow the address inputs with no clock delay. A register write becomes visible in the read data and in the reject outputs in the cycle after the clock edge that takes it. Before that edge, nothing changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_sel | input | 3 | Register select code |
| cfg_wr | input | 1 | Write strobe, taken on the rising clock edge |
| cfg_be | input | 4 | Byte write enables |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for the selected register (combinational) |
| pri_addr | input | 64 | Memory address seen on the primary side |
| pri_reject | output | 1 | Primary-side address falls in the enabled window |
| sec_addr | input | 64 | Memory address seen on the secondary side |
| sec_reject | output | 1 | Secondary-side address falls in the enabled window |

## Verification
The bench builds the block with its package defaults: 64-bit addresses, 32-bit data and a 20-bit granule. At these values a window placed above 4 GB is reachable, so a mismatch in the upper halves separates results that agree in the low 32 bits. Addresses one below the base and one past the limit land exactly on the 20-bit granule seams. A window of a single granule, with base and limit fields equal, checks that both implied fills are applied. Because the primary and secondary addresses are driven from different vector rows, a decode that mixes up the two sides gives wrong results.

// File: rtl/opq_pkg.sv
// Package: shared widths, select codes and reset values for the opaque
// window decoder. Assumes a 64-bit address split into two 32-bit halves.
package opq_pkg;
    localparam int ADDR_W    = 64;
    localparam int DATA_W    = 32;
    localparam int BE_W      = DATA_W / 8;
    localparam int HI_W      = ADDR_W - DATA_W;
    localparam int GRAN_BITS = 20;
    localparam int CAP_W     = 4;
    localparam int FLD_W     = DATA_W - GRAN_BITS;      // address bits 31:20
    localparam int LO_REG_W  = FLD_W + CAP_W;           // 16-bit low registers
    localparam int SEL_W     = 3;
    localparam int NUM_SIDES = 2;

    localparam logic [CAP_W-1:0] CAP_CODE = 4'b0001;    // 64-bit capable

    localparam logic [SEL_W-1:0] SEL_BASE_LO = 3'd0;
    localparam logic [SEL_W-1:0] SEL_LIM_LO  = 3'd1;
    localparam logic [SEL_W-1:0] SEL_BASE_HI = 3'd2;
    localparam logic [SEL_W-1:0] SEL_LIM_HI  = 3'd3;
    localparam logic [SEL_W-1:0] SEL_EN      = 3'd4;

    typedef struct packed {
        logic             en;
        logic [HI_W-1:0]  base_hi;
        logic [FLD_W-1:0] base_fld;
        logic [HI_W-1:0]  lim_hi;
        logic [FLD_W-1:0] lim_fld;
    } win_cfg_t;
endpackage

// File: rtl/opq_regfile.sv
// Register storage for the opaque window. Applies per-byte write enables,
// keeps the capability nibble read-only and returns combinational read data.
// Assumes a single-cycle write strobe sampled on the rising clock edge.
module opq_regfile
    import opq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEL_W-1:0]  sel,
    input  logic              wr,
    input  logic [BE_W-1:0]   be,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output win_cfg_t          cfg
);
    localparam int LO_BYTES = LO_REG_W / 8;

    win_cfg_t cfg_q;
    win_cfg_t cfg_d;

    // Merge selected bytes of a full-width register image.
    function automatic logic [DATA_W-1:0] merge_word(
        input logic [DATA_W-1:0] old_v,
        input logic [DATA_W-1:0] new_v,
        input logic [BE_W-1:0]   mask
    );
        logic [DATA_W-1:0] r;
        r = old_v;
        for (int b = 0; b < BE_W; b++) begin
            if (mask[b]) r[b*8 +: 8] = new_v[b*8 +: 8];
        end
        return r;
    endfunction

    // Merge bytes of a low register image, keeping only the writable field.
    function automatic logic [FLD_W-1:0] merge_field(
        input logic [FLD_W-1:0]  old_f,
        input logic [DATA_W-1:0] new_v,
        input logic [BE_W-1:0]   mask
    );
        logic [LO_REG_W-1:0] img;
        img = {old_f, CAP_CODE};
        for (int b = 0; b < LO_BYTES; b++) begin
            if (mask[b]) img[b*8 +: 8] = new_v[b*8 +: 8];
        end
        return img[LO_REG_W-1:CAP_W];
    endfunction

    // Next-state: apply a write to the selected register only.
    always_comb begin
        cfg_d = cfg_q;
        if (wr) begin
            case (sel)
                SEL_BASE_LO: cfg_d.base_fld = merge_field(cfg_q.base_fld, wdata, be);
                SEL_LIM_LO:  cfg_d.lim_fld  = merge_field(cfg_q.lim_fld, wdata, be);
                SEL_BASE_HI: cfg_d.base_hi  = merge_word(cfg_q.base_hi, wdata, be);
                SEL_LIM_HI:  cfg_d.lim_hi   = merge_word(cfg_q.lim_hi, wdata, be);
                SEL_EN:      if (be[0]) cfg_d.en = wdata[0];
                default:     cfg_d = cfg_q;
            endcase
        end
    end

    // State: reset leaves an empty, disabled window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q.en       <= 1'b0;
            cfg_q.base_hi  <= '1;
            cfg_q.base_fld <= '1;
            cfg_q.lim_hi   <= '0;
            cfg_q.lim_fld  <= '1;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    // Read mux: low registers carry the capability nibble.
    always_comb begin
        rdata = '0;
        case (sel)
            SEL_BASE_LO: rdata[LO_REG_W-1:0] = {cfg_q.base_fld, CAP_CODE};
            SEL_LIM_LO:  rdata[LO_REG_W-1:0] = {cfg_q.lim_fld, CAP_CODE};
            SEL_BASE_HI: rdata = cfg_q.base_hi;
            SEL_LIM_HI:  rdata = cfg_q.lim_hi;
            SEL_EN:      rdata[0] = cfg_q.en;
            default:     rdata = '0;
        endcase
    end

    assign cfg = cfg_q;

    // R1: first cycle out of reset shows the reset image.
    assert_reset_vals_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!cfg_q.en && cfg_q.base_hi == '1 && cfg_q.lim_hi == '0
                           && cfg_q.base_fld == '1 && cfg_q.lim_fld == '1));

    // R9: without a write nothing moves.
    assert_hold_no_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(wr)) |-> $stable(cfg_q));

    // R3: a cleared top byte enable keeps the top byte of base-high.
    assert_byte_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr && sel == SEL_BASE_HI && !be[BE_W-1]))
        |-> (cfg_q.base_hi[HI_W-1 -: 8] == $past(cfg_q.base_hi[HI_W-1 -: 8])));

    // R4: writes to unused codes change nothing.
    assert_bad_sel_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr && sel > SEL_EN)) |-> $stable(cfg_q));
endmodule

// File: rtl/opq_range_cmp.sv
// Inclusive unsigned range check of one address against the window.
// Purely combinational; clock and reset only qualify the assertions.
module opq_range_cmp
    import opq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] limit,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    logic above_base;
    logic below_limit;

    // Compare: both bounds inclusive, gated by the enable.
    always_comb begin
        above_base  = (addr >= base);
        below_limit = (addr <= limit);
        hit         = en && above_base && below_limit;
    end

    // R6: a disabled window never hits.
    assert_off_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !hit);

    // R7: an inverted window never hits.
    assert_empty_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (base > limit) |-> !hit);
endmodule

// File: rtl/opq_window_decoder.sv
// Top: opaque memory window registers plus one range check per bridge side.
// Assumes addresses are presented stably around the sampling point; the
// reject flags are combinational on the address inputs.
module opq_window_decoder
    import opq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic              cfg_wr,
    input  logic [BE_W-1:0]   cfg_be,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    input  logic [ADDR_W-1:0] pri_addr,
    output logic              pri_reject,
    input  logic [ADDR_W-1:0] sec_addr,
    output logic              sec_reject
);
    win_cfg_t          cfg;
    logic [ADDR_W-1:0] win_base;
    logic [ADDR_W-1:0] win_limit;
    logic [ADDR_W-1:0] side_addr [NUM_SIDES];
    logic              side_hit  [NUM_SIDES];

    opq_regfile i_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   (cfg_sel),
        .wr    (cfg_wr),
        .be    (cfg_be),
        .wdata (cfg_wdata),
        .rdata (cfg_rdata),
        .cfg   (cfg)
    );

    // Bounds: fill the granule bits with zeros (base) or ones (limit).
    always_comb begin
        win_base  = {cfg.base_hi, cfg.base_fld, {GRAN_BITS{1'b0}}};
        win_limit = {cfg.lim_hi, cfg.lim_fld, {GRAN_BITS{1'b1}}};
    end

    // Side fan-out: index 0 is primary, index 1 is secondary.
    always_comb begin
        side_addr[0] = pri_addr;
        side_addr[1] = sec_addr;
    end

    for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
        opq_range_cmp i_cmp (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (cfg.en),
            .base  (win_base),
            .limit (win_limit),
            .addr  (side_addr[s]),
            .hit   (side_hit[s])
        );
    end

    assign pri_reject = side_hit[0];
    assign sec_reject = side_hit[1];

    // R8: equal addresses on both sides decode alike.
    assert_sides_agree_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pri_addr == sec_addr) |-> (pri_reject == sec_reject));
endmodule

// File: tb/test_opq_window_decoder.sv
module test_opq_window_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic        cfg_wr = 1'b0;
    logic [3:0]  cfg_be = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic [63:0] pri_addr = '0;
    logic        pri_reject;
    logic [63:0] sec_addr = '0;
    logic        sec_reject;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    opq_window_decoder i_opq_window_decoder (
        .clk(clk), .rst_n(rst_n), .cfg_sel(cfg_sel), .cfg_wr(cfg_wr),
        .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .pri_addr(pri_addr), .pri_reject(pri_reject),
        .sec_addr(sec_addr), .sec_reject(sec_reject)
    );

    // Window 0x1_23400000 .. 0x1_567FFFFF; {expected reject, address}
    localparam int NV = 8;
    localparam logic [64:0] VEC [NV] = '{
        {1'b0, 64'h0000_0001_233F_FFFF},
        {1'b1, 64'h0000_0001_2340_0000},
        {1'b1, 64'h0000_0001_2340_0001},
        {1'b1, 64'h0000_0001_4000_0000},
        {1'b1, 64'h0000_0001_567F_FFFF},
        {1'b0, 64'h0000_0001_5680_0000},
        {1'b0, 64'h0000_0000_2340_0000},
        {1'b0, 64'h0000_0002_2340_0000}
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] sel, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        cfg_sel = sel; cfg_be = be; cfg_wdata = d; cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0; cfg_be = '0;
    endtask

    task automatic rd_chk(input string req, input logic [2:0] sel, input logic [31:0] exp);
        cfg_sel = sel;
        #1;
        check(req, {32'h0, cfg_rdata}, {32'h0, exp});
    endtask

    task automatic addr_chk(input string req, input logic [63:0] a, input logic exp);
        pri_addr = a; sec_addr = a;
        #1;
        check(req, {63'h0, pri_reject}, {63'h0, exp});
        check(req, {63'h0, sec_reject}, {63'h0, exp});
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1: reset image and no rejects
        rd_chk("R1 base-low", 3'd0, 32'h0000_FFF1);
        rd_chk("R1 limit-low", 3'd1, 32'h0000_FFF1);
        rd_chk("R1 base-high", 3'd2, 32'hFFFF_FFFF);
        rd_chk("R1 limit-high", 3'd3, 32'h0000_0000);
        rd_chk("R1 enable", 3'd4, 32'h0000_0000);
        addr_chk("R1 idle", 64'hFFFF_FFFF_FFF0_0000, 1'b0);
        wr_reg(3'd4, 4'h1, 32'h1);
        addr_chk("R1 enabled-empty", 64'hFFFF_FFFF_FFF0_0000, 1'b0);
        addr_chk("R1 enabled-empty", 64'h0000_0000_FFFF_FFFF, 1'b0);

        // R5: configure window and walk the vector table on both sides
        wr_reg(3'd2, 4'hF, 32'h0000_0001);
        wr_reg(3'd0, 4'h3, 32'h0000_2340);
        wr_reg(3'd3, 4'hF, 32'h0000_0001);
        wr_reg(3'd1, 4'h3, 32'h0000_5670);
        rd_chk("R5 base-low readback", 3'd0, 32'h0000_2341);
        rd_chk("R5 limit-low readback", 3'd1, 32'h0000_5671);
        for (int i = 0; i < NV; i++) begin
            pri_addr = VEC[i][63:0];
            sec_addr = VEC[(i + 3) % NV][63:0];
            #1;
            check("R5 pri vector", {63'h0, pri_reject}, {63'h0, VEC[i][64]});
            check("R8 sec vector", {63'h0, sec_reject}, {63'h0, VEC[(i + 3) % NV][64]});
        end

        // R9: write takes effect only after the edge
        pri_addr = 64'h0000_0001_3000_0000; sec_addr = pri_addr;
        @(negedge clk);
        cfg_sel = 3'd4; cfg_be = 4'h1; cfg_wdata = 32'h0; cfg_wr = 1'b1;
        #1;
        check("R9 before edge", {63'h0, pri_reject}, 64'h1);
        @(negedge clk);
        cfg_wr = 1'b0;
        #1;
        check("R9 after edge", {63'h0, pri_reject}, 64'h0);
        // R6: disabled window inside address
        addr_chk("R6 disabled", 64'h0000_0001_2340_0000, 1'b0);
        wr_reg(3'd4, 4'h0, 32'h1);
        addr_chk("R3 enable be=0 ignored", 64'h0000_0001_2340_0000, 1'b0);
        wr_reg(3'd4, 4'h1, 32'h1);
        addr_chk("R6 re-enabled", 64'h0000_0001_2340_0000, 1'b1);

        // R7: base above limit
        wr_reg(3'd0, 4'h3, 32'h0000_6000);
        wr_reg(3'd1, 4'h3, 32'h0000_5FF0);
        addr_chk("R7 inverted", 64'h0000_0001_5FF0_0000, 1'b0);
        addr_chk("R7 inverted", 64'h0000_0001_6000_0000, 1'b0);
        // R5: single-granule window
        wr_reg(3'd1, 4'h3, 32'h0000_6000);
        addr_chk("R5 one-MB low", 64'h0000_0001_6000_0000, 1'b1);
        addr_chk("R5 one-MB high", 64'h0000_0001_600F_FFFF, 1'b1);
        addr_chk("R5 one-MB past", 64'h0000_0001_6010_0000, 1'b0);
        addr_chk("R5 one-MB below", 64'h0000_0001_5FFF_FFFF, 1'b0);

        // R2: capability nibble is read-only
        wr_reg(3'd1, 4'h3, 32'hFFFF_FFFF);
        rd_chk("R2 limit-low ro", 3'd1, 32'h0000_FFF1);
        // R3: byte enables
        wr_reg(3'd2, 4'b0101, 32'hAABB_CCDD);
        rd_chk("R3 base-high bytes", 3'd2, 32'h00BB_00DD);
        wr_reg(3'd0, 4'b0001, 32'h0000_1234);
        rd_chk("R3 base-low byte0", 3'd0, 32'h0000_6031);
        // R4: unused codes
        wr_reg(3'd5, 4'hF, 32'hFFFF_FFFF);
        rd_chk("R4 code5", 3'd5, 32'h0);
        rd_chk("R4 code6", 3'd6, 32'h0);
        rd_chk("R4 limit-high kept", 3'd3, 32'h0000_0001);
        rd_chk("R4 enable kept", 3'd4, 32'h0000_0001);

        // R1: reset again mid-run
        do_reset();
        rd_chk("R1 re-reset enable", 3'd4, 32'h0);
        rd_chk("R1 re-reset base-high", 3'd2, 32'hFFFF_FFFF);
        addr_chk("R1 re-reset idle", 64'h0000_0001_6000_0000, 1'b0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule